// File: doc/BRIEF.md
# Scanline Wait and Display-Fetch Halt Controller

This block governs when the CPU may use a bus that it shares with the display fetcher, in a system where raster timing paces everything. A single pixel clock drives the block. It counts the horizontal beam position across each line and the line number within each frame. From the horizontal phase it derives a CPU clock-enable, so that the CPU gets exactly one cycle for every two pixels.

Two things hold the CPU. The first is a display fetch request, which always wins the bus: while it is asserted, ready drops and no clock-enable pulse is issued in that slot. The second is a write to the line-wait register, which stalls the CPU until the beam reaches a fixed release column near the start of horizontal blank. Software uses this register to place display-register updates at a known horizontal position. The register has no data input, so only the strobe at the decoded address matters. When both holds are present, ready returns only after both have cleared.

Top module: `scan_halt_ctrl`

## Requirements
- R1: While rst_ni is low, hpos_o and vpos_o read 0 and no line-wait is pending, so ready_o is high whenever dma_req_i is low.
- R2: hpos_o rises by one on every pixel clock and returns to 0 after 2*LINE_SLOTS-1 (455 by default).
- R3: vpos_o rises by one on each clock where hpos_o wraps, leaves its value unchanged on every other clock, and returns to 0 after LINES-1 (261 by default).
- R4: cpu_ce_o is high only on clocks where hpos_o is even and ready_o is high, which gives one CPU slot per two pixels.
- R5: In the same clock that dma_req_i is high, ready_o and cpu_ce_o are both low.
- R6: A clock edge that sees wr_en_i high with wr_addr_i equal to WAIT_ADDR drives ready_o low from the next clock onward.
- R7: A pending line-wait clears at the edge where hpos_o equals REL_POS (an even column, 440 by default). ready_o is high from hpos_o = REL_POS+1, and the first cpu_ce_o pulse after the wait comes at REL_POS+2.
- R8: A write strobe at any address other than WAIT_ADDR has no effect on ready_o or cpu_ce_o.
- R9: A wait write taken at the edge where hpos_o equals REL_POS keeps the CPU halted until REL_POS on the following line.
- R10: If dma_req_i is high when a line-wait clears, ready_o stays low until dma_req_i also falls.
- R11: A second wait write while a wait is already pending does not extend the halt past the next release edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | CPU register write strobe |
| wr_addr_i | input | ADDR_W | CPU register write address |
| dma_req_i | input | 1 | Display fetcher bus request for the current slot |
| ready_o | output | 1 | CPU may proceed (high) or is held (low) |
| cpu_ce_o | output | 1 | CPU clock-enable, one pulse per granted slot |
| hpos_o | output | HW | Horizontal beam position in pixel clocks |
| vpos_o | output | VW | Line number within the frame |

## Verification
If the horizontal count is corrupted, it shows up at hpos_o on the very next clock. It also moves the clock-enable parity and the release column, so a slip of even one pixel causes a mismatch within a line. If the wait latch has the wrong state, ready_o shows it one clock after the faulty edge. It may instead appear as a release that comes a line early or late. The bench therefore compares every port on every clock of a short configuration over several frames. It runs writes at ordinary columns, at the release column and at the last column, writes to every non-matching address, and fetch requests placed before, during and across a release.

// File: rtl/scan_halt_pkg.sv
package scan_halt_pkg;
  // Slot phase from the low bit of the horizontal position
  typedef enum logic {
    PH_CPU = 1'b0,
    PH_GAP = 1'b1
  } slot_phase_e;
endpackage

// File: rtl/beam_counter.sv
module beam_counter #(
  parameter int unsigned H_PIX = 456,
  parameter int unsigned LINES = 262,
  localparam int unsigned HW = $clog2(H_PIX),
  localparam int unsigned VW = $clog2(LINES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [HW-1:0] h_o,
  output logic [VW-1:0] v_o
);
  localparam logic [HW-1:0] H_LAST = HW'(H_PIX - 1);
  localparam logic [VW-1:0] V_LAST = VW'(LINES - 1);

  logic h_wrap;
  assign h_wrap = (h_o == H_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_o <= '0;
    end else if (h_wrap) begin
      h_o <= '0;
    end else begin
      h_o <= h_o + HW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o <= '0;
    end else if (h_wrap) begin
      v_o <= (v_o == V_LAST) ? '0 : v_o + VW'(1);
    end
  end
endmodule

// File: rtl/line_wait_latch.sv
module line_wait_latch #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned WAIT_ADDR = 8'h0A,
  parameter int unsigned REL_POS   = 440,
  parameter int unsigned HW        = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [HW-1:0]     h_i,
  output logic              wait_o
);
  logic hit, rel;
  assign hit = wr_en_i && (wr_addr_i == ADDR_W'(WAIT_ADDR));
  assign rel = (h_i == HW'(REL_POS));

  // A write on the release column wins: the wait runs a full line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_o <= 1'b0;
    end else if (hit) begin
      wait_o <= 1'b1;
    end else if (rel) begin
      wait_o <= 1'b0;
    end
  end
endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter
  import scan_halt_pkg::*;
(
  input  logic phase_bit_i,
  input  logic wait_i,
  input  logic dma_req_i,
  output logic ready_o,
  output logic cpu_ce_o
);
  slot_phase_e phase;
  assign phase    = slot_phase_e'(phase_bit_i);
  // Display fetch has priority over the CPU in every slot
  assign ready_o  = !wait_i && !dma_req_i;
  assign cpu_ce_o = ready_o && (phase == PH_CPU);
endmodule

// File: rtl/scan_halt_ctrl.sv
module scan_halt_ctrl #(
  parameter int unsigned LINE_SLOTS = 228,
  parameter int unsigned LINES      = 262,
  parameter int unsigned REL_POS    = 440,  // must be even and below 2*LINE_SLOTS
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned WAIT_ADDR  = 8'h0A,
  localparam int unsigned H_PIX = 2 * LINE_SLOTS,
  localparam int unsigned HW    = $clog2(H_PIX),
  localparam int unsigned VW    = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              dma_req_i,
  output logic              ready_o,
  output logic              cpu_ce_o,
  output logic [HW-1:0]     hpos_o,
  output logic [VW-1:0]     vpos_o
);
  logic wait_q;

  beam_counter #(.H_PIX(H_PIX), .LINES(LINES)) u_beam (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .h_o   (hpos_o),
    .v_o   (vpos_o)
  );

  line_wait_latch #(
    .ADDR_W(ADDR_W), .WAIT_ADDR(WAIT_ADDR), .REL_POS(REL_POS), .HW(HW)
  ) u_wait (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .h_i      (hpos_o),
    .wait_o   (wait_q)
  );

  slot_arbiter u_arb (
    .phase_bit_i(hpos_o[0]),
    .wait_i     (wait_q),
    .dma_req_i  (dma_req_i),
    .ready_o    (ready_o),
    .cpu_ce_o   (cpu_ce_o)
  );
endmodule

// File: rtl/scan_halt_ctrl_chk.sv
module scan_halt_ctrl_chk #(
  parameter int unsigned H_PIX     = 456,
  parameter int unsigned LINES     = 262,
  parameter int unsigned REL_POS   = 440,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned WAIT_ADDR = 8'h0A,
  parameter int unsigned HW        = 9,
  parameter int unsigned VW        = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              dma_req_i,
  input logic              ready_o,
  input logic              cpu_ce_o,
  input logic [HW-1:0]     hpos_o,
  input logic [VW-1:0]     vpos_o
);
  logic hit;
  assign hit = wr_en_i && (wr_addr_i == ADDR_W'(WAIT_ADDR));

  a_r2_h_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hpos_o != HW'(H_PIX - 1)) |=> (hpos_o == $past(hpos_o) + HW'(1)));
  a_r2_h_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hpos_o == HW'(H_PIX - 1)) |=> (hpos_o == '0));
  a_r3_v_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hpos_o != HW'(H_PIX - 1)) |=> $stable(vpos_o));
  a_r3_v_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hpos_o == HW'(H_PIX - 1) && vpos_o == VW'(LINES - 1)) |=> (vpos_o == '0));
  a_r4_ce_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ce_o |-> (!hpos_o[0] && ready_o));
  a_r5_dma_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_i |-> (!ready_o && !cpu_ce_o));
  a_r6_wait_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> !ready_o);
  a_r7_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hpos_o == HW'(REL_POS) && !hit) |=> (ready_o == !dma_req_i));
  a_r9_hold_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !dma_req_i && hpos_o != HW'(REL_POS)) |=> !ready_o);
endmodule

bind scan_halt_ctrl scan_halt_ctrl_chk #(
  .H_PIX(H_PIX), .LINES(LINES), .REL_POS(REL_POS),
  .ADDR_W(ADDR_W), .WAIT_ADDR(WAIT_ADDR), .HW(HW), .VW(VW)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .dma_req_i(dma_req_i),
  .ready_o  (ready_o),
  .cpu_ce_o (cpu_ce_o),
  .hpos_o   (hpos_o),
  .vpos_o   (vpos_o)
);

// File: tb/tb_scan_halt_ctrl.sv
`timescale 1ns/1ps
module tb_scan_halt_ctrl;
  localparam int SLOTS = 8;
  localparam int HP    = 2 * SLOTS;
  localparam int NL    = 3;
  localparam int REL   = 10;
  localparam int AW    = 4;
  localparam int WA    = 4'hA;
  localparam int NCYC  = 220;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic          dma = 1'b0;
  logic          ready, ce;
  logic [3:0]    hpos;
  logic [1:0]    vpos;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  scan_halt_ctrl #(
    .LINE_SLOTS(SLOTS), .LINES(NL), .REL_POS(REL), .ADDR_W(AW), .WAIT_ADDR(WA)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .dma_req_i(dma), .ready_o(ready), .cpu_ce_o(ce), .hpos_o(hpos), .vpos_o(vpos)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Stimulus plan per cycle index n after reset release
  function automatic bit dma_at(int n);
    return (n >= 30 && n <= 33) || (n >= 104 && n <= 109) || (n >= 196 && n <= 197);
  endfunction

  function automatic bit wr_at(int n);
    return n == 20 || n == 42 || n == 100 || n == 150 || n == 153 || n == 175 ||
           (n >= 70 && n <= 85);
  endfunction

  function automatic int addr_at(int n);
    if (n >= 70 && n <= 85) return ((n - 70) == WA) ? 4'hF : (n - 70);
    return WA;
  endfunction

  function automatic string tag_at(int n, bit d, bit w);
    if (d && w) return "R10";
    if (d) return "R5";
    if (n >= 42 && n <= 59) return "R9";
    if (n >= 70 && n <= 90) return "R8";
    if (n >= 150 && n <= 156) return "R11";
    if (w) return "R6";
    return "R7";
  endfunction

  initial begin
    int n;
    bit w;
    // R1: reset values
    repeat (3) @(negedge clk);
    #1;
    chk("R1 hpos", hpos, 0);
    chk("R1 vpos", vpos, 0);
    chk("R1 ready", ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    w = 0;
    for (int i = 0; i < NCYC; i++) begin
      int eh, ev;
      bit d, er;
      d       = dma_at(n);
      dma     = d;
      wr_en   = wr_at(n);
      wr_addr = AW'(addr_at(n));
      #1;
      eh = n % HP;
      ev = (n / HP) % NL;
      er = !w && !d;
      chk("R2 hpos", hpos, eh);
      chk("R3 vpos", vpos, ev);
      chk({tag_at(n, d, w), " ready"}, ready, er);
      chk("R4 cpu_ce", ce, er && (eh % 2 == 0));
      // model of the wait state across the coming edge
      if (wr_en && wr_addr == AW'(WA)) w = 1;
      else if (eh == REL) w = 0;
      n++;
      @(negedge clk);
    end
    wr_en = 1'b0;
    dma   = 1'b0;
    done  = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule